// File: doc/BRIEF.md
# Full-Circle Quadrant Fold and Unfold Stage for a CORDIC Engine

A CORDIC engine that works in a half-plane only converges for angles between -π/2 and +π/2, and in vectoring mode only for vectors with a non-negative abscissa. This stage wraps such an engine so that the pair behaves like a full four-quadrant unit. On the way in, it folds each sample into the engine's valid region and writes down what it did. On the way out, it applies the inverse correction to the engine result. The input and output angle range becomes -π to +π, and in vectoring mode the result phase follows atan2.

Each input sample carries its own mode bit, so rotation and vectoring samples may be interleaved. The fold decision for a sample is packed into a small correction tag. A delay line carries the tag for exactly the engine's fixed latency, so each engine result meets its own tag. The stage adds two register stages in total: one for the fold and one for the unfold. Angles are signed W-bit fractions of π, where π equals 2^(W-2). Linear values are signed W-bit two's complement and pass through in the engine's own scale.

Top module: `quad_fold_rotator`

## Requirements
- R1: Rotation mode, angle above +π/2 (above 2^(W-3)). The stage passes angle-π to the engine and negates the engine's X and Y results. The final vector therefore equals the input vector rotated by the original angle.
- R2: Rotation mode, angle below -π/2. The stage passes angle+π to the engine and negates the engine's X and Y results, again giving the rotation by the original angle.
- R3: Rotation mode, angle within [-π/2, +π/2]. The sample reaches the engine unchanged, and the engine results leave unchanged.
- R4: Vectoring mode, negative X input. The engine receives (-X, -Y). The output phase then takes the engine phase plus π when the original Y is zero or positive, and minus π when it is negative. Quadrant 2 thus gives π-q1, quadrant 3 gives -π+q1, and (-0.2, 0.3) gives about 2.159 rad.
- R5: Vectoring mode, X zero or positive. The sample passes through unchanged. The magnitude output is the engine's magnitude in every vectoring case.
- R6: Every sample handed to the engine lies in its valid region: angle within ±2^(W-3) in rotation mode, and X not negative in vectoring mode.
- R7: The engine-side valid rises exactly 1 cycle after an accepted input. The output valid rises exactly 1 cycle after an engine valid. End to end, the delay is ENG_LAT+2 cycles, with one sample accepted per cycle.
- R8: While reset is asserted (active-low, asynchronous), both the engine-side valid and the output valid are low.
- R9: Under back-to-back traffic that mixes modes and fold decisions, each result receives the correction of its own sample.
- R10: Vectoring mode, Y zero and X negative. The output phase is +π (2^(W-2)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input sample valid |
| inVector | input | 1 | 1 = vectoring sample, 0 = rotation sample |
| inX | input | W | Input abscissa |
| inY | input | W | Input ordinate |
| inA | input | W | Input angle, fraction of π |
| toEngValid | output | 1 | Folded sample valid, to engine |
| toEngX | output | W | Folded abscissa, to engine |
| toEngY | output | W | Folded ordinate, to engine |
| toEngA | output | W | Folded angle, to engine |
| fromEngValid | input | 1 | Engine result valid |
| fromEngX | input | W | Engine X result |
| fromEngY | input | W | Engine Y result |
| fromEngA | input | W | Engine angle result |
| outValid | output | 1 | Corrected result valid |
| outX | output | W | Corrected X |
| outY | output | W | Corrected Y |
| outA | output | W | Corrected angle |

## Verification
Under streaming traffic, the fold of a new sample and the unfold of a sample that entered ENG_LAT+1 cycles earlier happen in the same clock cycle. The two operations use different tags, so a tag that slips by one stage would apply one sample's correction to another sample. The bench provokes this with an ideal floating-point engine model of fixed latency. It sends unbroken runs that alternate rotation and vectoring samples with and without a fold. It judges every result against a full-circle rotation or an atan2 computed directly from the original sample, within one LSB, and checks that the result arrives at exactly its expected cycle.

// File: rtl/quad_fold_pkg.sv
package quad_fold_pkg;

  // Correction record carried alongside the engine
  typedef struct packed {
    logic live;   // slot holds a real sample
    logic flip;   // sample was folded
    logic vec;    // sample is a vectoring sample
    logic yNeg;   // original ordinate was negative
  } foldTag_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     preLoad;
    logic     postLoad;
    foldTag_t postTag;
  } foldStrobe_t;

endpackage

// File: rtl/quad_fold_ctrl.sv
module quad_fold_ctrl
  import quad_fold_pkg::*;
#(
  parameter int ENG_LAT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        fromEngValid,
  input  foldTag_t    preTag,
  output foldStrobe_t strb,
  output logic        toEngValid,
  output logic        outValid
);

  // stage 0 sits beside the fold registers, stage ENG_LAT meets the engine result
  foldTag_t tagPipe [ENG_LAT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagPipe[0] <= '0;
      toEngValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      tagPipe[0] <= preTag;
      toEngValid <= inValid;
      outValid   <= fromEngValid;
    end
  end

  for (genvar s = 1; s <= ENG_LAT; s++) begin : g_tagDelay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tagPipe[s] <= '0;
      else       tagPipe[s] <= tagPipe[s-1];
    end
  end

  always_comb begin
    strb.preLoad  = inValid;
    strb.postLoad = fromEngValid;
    strb.postTag  = tagPipe[ENG_LAT];
  end

endmodule

// File: rtl/quad_fold_datapath.sv
module quad_fold_datapath
  import quad_fold_pkg::*;
#(
  parameter int W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  foldStrobe_t        strb,
  input  logic               inVector,
  input  logic signed [W-1:0] inX,
  input  logic signed [W-1:0] inY,
  input  logic signed [W-1:0] inA,
  input  logic signed [W-1:0] fromEngX,
  input  logic signed [W-1:0] fromEngY,
  input  logic signed [W-1:0] fromEngA,
  output foldTag_t           preTag,
  output logic signed [W-1:0] toEngX,
  output logic signed [W-1:0] toEngY,
  output logic signed [W-1:0] toEngA,
  output logic signed [W-1:0] outX,
  output logic signed [W-1:0] outY,
  output logic signed [W-1:0] outA
);

  localparam logic signed [W-1:0] PI_V   = W'(2**(W-2));
  localparam logic signed [W-1:0] HALF_V = W'(2**(W-3));

  logic signed [W-1:0] foldX, foldY, foldA;
  logic signed [W-1:0] fixX, fixY, fixA;
  logic aboveHalf, belowHalf;

  // fold into the engine's half plane
  always_comb begin
    aboveHalf   = inA > HALF_V;
    belowHalf   = inA < -HALF_V;
    preTag.live = strb.preLoad;
    preTag.vec  = inVector;
    preTag.yNeg = inY[W-1];
    foldX = inX;
    foldY = inY;
    foldA = inA;
    if (inVector) begin
      preTag.flip = inX[W-1];
      if (inX[W-1]) begin
        foldX = -inX;
        foldY = -inY;
      end
    end else begin
      preTag.flip = aboveHalf | belowHalf;
      if (aboveHalf)      foldA = inA - PI_V;
      else if (belowHalf) foldA = inA + PI_V;
    end
  end

  // undo the fold on the engine result
  always_comb begin
    fixX = fromEngX;
    fixY = fromEngY;
    fixA = fromEngA;
    if (strb.postTag.flip) begin
      if (strb.postTag.vec) begin
        fixA = strb.postTag.yNeg ? fromEngA - PI_V : fromEngA + PI_V;
      end else begin
        fixX = -fromEngX;
        fixY = -fromEngY;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toEngX <= '0; toEngY <= '0; toEngA <= '0;
      outX   <= '0; outY   <= '0; outA   <= '0;
    end else begin
      if (strb.preLoad) begin
        toEngX <= foldX; toEngY <= foldY; toEngA <= foldA;
      end
      if (strb.postLoad) begin
        outX <= fixX; outY <= fixY; outA <= fixA;
      end
    end
  end

endmodule

// File: rtl/quad_fold_rotator.sv
module quad_fold_rotator
  import quad_fold_pkg::*;
#(
  parameter int W       = 10,
  parameter int ENG_LAT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inVector,
  input  logic signed [W-1:0] inX,
  input  logic signed [W-1:0] inY,
  input  logic signed [W-1:0] inA,
  output logic               toEngValid,
  output logic signed [W-1:0] toEngX,
  output logic signed [W-1:0] toEngY,
  output logic signed [W-1:0] toEngA,
  input  logic               fromEngValid,
  input  logic signed [W-1:0] fromEngX,
  input  logic signed [W-1:0] fromEngY,
  input  logic signed [W-1:0] fromEngA,
  output logic               outValid,
  output logic signed [W-1:0] outX,
  output logic signed [W-1:0] outY,
  output logic signed [W-1:0] outA
);

  foldStrobe_t strb;
  foldTag_t    preTag;

  quad_fold_ctrl #(.ENG_LAT(ENG_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fromEngValid(fromEngValid),
    .preTag(preTag), .strb(strb), .toEngValid(toEngValid), .outValid(outValid)
  );

  quad_fold_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inVector(inVector),
    .inX(inX), .inY(inY), .inA(inA),
    .fromEngX(fromEngX), .fromEngY(fromEngY), .fromEngA(fromEngA),
    .preTag(preTag), .toEngX(toEngX), .toEngY(toEngY), .toEngA(toEngA),
    .outX(outX), .outY(outY), .outA(outA)
  );

endmodule

// File: rtl/quad_fold_checker.sv
module quad_fold_checker #(
  parameter int W = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inVector,
  input logic               toEngValid,
  input logic signed [W-1:0] toEngX,
  input logic signed [W-1:0] toEngA,
  input logic               fromEngValid,
  input logic signed [W-1:0] fromEngX,
  input logic signed [W-1:0] fromEngA,
  input logic               tagLive,
  input logic               outValid,
  input logic signed [W-1:0] outX,
  input logic signed [W-1:0] outA
);

  localparam logic signed [W-1:0] PI_V   = W'(2**(W-2));
  localparam logic signed [W-1:0] HALF_V = W'(2**(W-3));
  localparam logic [W-1:0]        NEG_PI = -PI_V;

  // R6: rotation samples reach the engine inside ±π/2
  p_eng_angle_r6: assert property (@(posedge clk) disable iff (!rstN)
    toEngValid && !$past(inVector) |-> (toEngA <= HALF_V) && (toEngA >= -HALF_V));

  // R6: vectoring samples reach the engine with X not negative
  p_eng_xpos_r6: assert property (@(posedge clk) disable iff (!rstN)
    toEngValid && $past(inVector) |-> !toEngX[W-1]);

  // R7: fold stage costs one cycle
  p_pre_lat_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> toEngValid);
  p_pre_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !toEngValid);

  // R7: unfold stage costs one cycle
  p_post_lat_r7: assert property (@(posedge clk) disable iff (!rstN)
    fromEngValid |=> outValid);
  p_post_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !fromEngValid |=> !outValid);

  // R9: engine result meets a live tag from the delay line
  p_tag_pair_r9: assert property (@(posedge clk) disable iff (!rstN)
    fromEngValid |-> tagLive);

  // R4: phase correction is zero or exactly ±π
  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((outA - $past(fromEngA)) == '0) || ((outA - $past(fromEngA)) == PI_V)
                 || ((outA - $past(fromEngA)) == NEG_PI));

  // R1: X correction keeps the engine value or negates it
  p_x_sign_r1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outX == $past(fromEngX)) || (outX == -$past(fromEngX)));

endmodule

bind quad_fold_rotator quad_fold_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inVector(inVector),
  .toEngValid(toEngValid), .toEngX(toEngX), .toEngA(toEngA),
  .fromEngValid(fromEngValid), .fromEngX(fromEngX), .fromEngA(fromEngA),
  .tagLive(strb.postTag.live), .outValid(outValid), .outX(outX), .outA(outA)
);

// File: tb/quad_fold_rotator_tb.sv
module quad_fold_rotator_tb;
  localparam int W   = 10;
  localparam int L   = 5;
  localparam int ONE = 2**(W-2);   // 1.0 linear and π angular
  localparam real PI_R = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic inValid = 1'b0, inVector = 1'b0;
  logic signed [W-1:0] inX = '0, inY = '0, inA = '0;
  logic toEngValid, outValid;
  logic signed [W-1:0] toEngX, toEngY, toEngA, outX, outY, outA;
  logic fromEngValid;
  logic signed [W-1:0] fromEngX, fromEngY, fromEngA;

  quad_fold_rotator #(.W(W), .ENG_LAT(L)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVector(inVector),
    .inX(inX), .inY(inY), .inA(inA),
    .toEngValid(toEngValid), .toEngX(toEngX), .toEngY(toEngY), .toEngA(toEngA),
    .fromEngValid(fromEngValid), .fromEngX(fromEngX), .fromEngY(fromEngY), .fromEngA(fromEngA),
    .outValid(outValid), .outX(outX), .outY(outY), .outA(outA)
  );

  int checks = 0, errors = 0, cycleCnt = 0;
  bit done = 0;

  function automatic int rnd(real r);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  // ideal half-plane engine model, fixed latency L
  logic vecD = 1'b0;
  logic eV [L];
  int   eX [L], eY [L], eA [L];
  real  rx, ry, ra;
  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    vecD <= inVector;
    rx = real'(toEngX); ry = real'(toEngY); ra = real'(toEngA) / ONE * PI_R;
    eV[0] <= toEngValid;
    if (vecD) begin
      eX[0] <= rnd($sqrt(rx*rx + ry*ry));
      eY[0] <= 0;
      eA[0] <= (rx == 0.0 && ry == 0.0) ? 0 : rnd($atan2(ry, rx) / PI_R * ONE);
    end else begin
      eX[0] <= rnd(rx*$cos(ra) - ry*$sin(ra));
      eY[0] <= rnd(ry*$cos(ra) + rx*$sin(ra));
      eA[0] <= 0;
    end
    for (int s = 1; s < L; s++) begin
      eV[s] <= eV[s-1]; eX[s] <= eX[s-1]; eY[s] <= eY[s-1]; eA[s] <= eA[s-1];
    end
  end
  assign fromEngValid = eV[L-1];
  assign fromEngX = W'(eX[L-1]);
  assign fromEngY = W'(eY[L-1]);
  assign fromEngA = W'(eA[L-1]);

  // expected results, in send order
  int expX [1024], expY [1024], expA [1024], sendCyc [1024];
  string expTag [1024];
  int txIdx = 0, rxIdx = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit near(input int a, input int b);
    return (a - b <= 1) && (b - a <= 1);
  endfunction

  // output and engine-side monitor
  always @(negedge clk) begin
    if (rstN && toEngValid) begin
      if (vecD) chk(!toEngX[W-1], "R6", "engine X sign", int'(toEngX), 0);
      else chk(int'(toEngA) <= ONE/2 && int'(toEngA) >= -ONE/2, "R6", "engine angle", int'(toEngA), ONE/2);
    end
    if (rstN && outValid) begin
      chk(rxIdx < txIdx, "R7", "unexpected result", rxIdx, txIdx);
      if (rxIdx < txIdx) begin
        chk(cycleCnt - sendCyc[rxIdx] == L + 2, "R7", "latency", cycleCnt - sendCyc[rxIdx], L + 2);
        chk(near(int'(outX), expX[rxIdx]), expTag[rxIdx], "outX", int'(outX), expX[rxIdx]);
        chk(near(int'(outY), expY[rxIdx]), expTag[rxIdx], "outY", int'(outY), expY[rxIdx]);
        chk(near(int'(outA), expA[rxIdx]), expTag[rxIdx], "outA", int'(outA), expA[rxIdx]);
        rxIdx++;
      end
    end
  end

  // one sample for the next rising edge; called at a falling edge
  task automatic send(input bit vec, input int x, input int y, input int a, input string forceTag);
    real fx, fy, fa;
    inValid = 1'b1; inVector = vec;
    inX = W'(x); inY = W'(y); inA = W'(a);
    fx = real'(x); fy = real'(y); fa = real'(a) / ONE * PI_R;
    if (vec) begin
      expX[txIdx] = rnd($sqrt(fx*fx + fy*fy));
      expY[txIdx] = 0;
      expA[txIdx] = (x == 0 && y == 0) ? 0 : rnd($atan2(fy, fx) / PI_R * ONE);
      expTag[txIdx] = (x < 0) ? ((y == 0) ? "R10" : "R4") : "R5";
    end else begin
      expX[txIdx] = rnd(fx*$cos(fa) - fy*$sin(fa));
      expY[txIdx] = rnd(fy*$cos(fa) + fx*$sin(fa));
      expA[txIdx] = 0;
      expTag[txIdx] = (a > ONE/2) ? "R1" : ((a < -ONE/2) ? "R2" : "R3");
    end
    if (forceTag != "") expTag[txIdx] = forceTag;
    sendCyc[txIdx] = cycleCnt;
    txIdx++;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic flush();
    repeat (L + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset holds both valids low
    chk(!outValid, "R8", "outValid in reset", int'(outValid), 0);
    chk(!toEngValid, "R8", "toEngValid in reset", int'(toEngValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // rotation sweep over the full circle, two vectors, with bubbles
    for (int a = -ONE; a <= ONE; a += 4) begin
      send(1'b0, 200, 50, a, "");
      send(1'b0, -60, 170, a, "");
      if (a % 20 == 0) @(negedge clk);
    end
    flush();

    // vectoring grid over all four quadrants and both axes
    for (int x = -ONE; x <= ONE; x += 32)
      for (int y = -ONE; y <= ONE; y += 32)
        if (x*x + y*y <= ONE*ONE) send(1'b1, x, y, 0, "");
    flush();

    // worked cases: (-0.2, 0.3) and (-0.2, -0.3); negative X on the axis
    send(1'b1, -51, 77, 0, "R4");
    send(1'b1, -51, -77, 0, "R4");
    send(1'b1, -100, 0, 0, "R10");
    flush();

    // R9: unbroken mixed traffic, fold and unfold in the same cycles
    for (int k = 0; k < 40; k++) begin
      case (k % 4)
        0: send(1'b0, 150, -40, 230 - k, "R9");
        1: send(1'b1, -90 + k, 60 - k*3, 0, "R9");
        2: send(1'b0, -30, 120, -20 + k, "R9");
        default: send(1'b1, 70, -k*4, 0, "R9");
      endcase
    end
    flush();
    chk(rxIdx == txIdx, "R7", "result count", rxIdx, txIdx);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R7 watchdog: actual %0d expected %0d results", rxIdx, txIdx);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule